// File: doc/BRIEF.md
# SPI Port with Buffered Status and Selectable Interrupt

This block is a serial peripheral port that moves 8-bit words through a transmit queue and a receive queue, each eight entries deep. Software reaches it through a small register port with three addresses: a control register, a status register and a data register. Writing the data register queues a word for sending. Reading it takes the oldest received word. The serial side runs clock mode 0, where the clock idles low, data is captured on the rising edge and changed on the falling edge. The port can act as the clock master or as a slave that follows an external clock and select line.

The status register gives the fill level of the queues, whether the shifter is idle, and a sticky flag that records a dropped receive word. A three-bit selector chooses which buffer or shifter event drives the single interrupt output. Four of the choices are level conditions. The other four are one-cycle event pulses. A stop-in-idle control freezes the serial engine while an external idle input is high.

Top module: `spibuf_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x28 (shifter-empty and receive-empty set, all else clear), irq is 0, port_owned is 0, ss_n_out is 1 and sck_out is 0.
- R2: Control bit 0 enables the port and drives port_owned. While it is 0 both queues are held empty, data-register writes are dropped, and ss_n_out stays 1 with sck_out and sdo at 0.
- R3: Control bit 2 selects the master role. In this role each queued word is sent MSB first on sdo, with ss_n_out low for the whole word. sck_out has a period of 2*HALF_DIV system clocks, and sck_out only rises while ss_n_out is low. The bits sampled on sdi at each rising edge enter the receive queue in order.
- R4: Status bits 2:0 hold the number of words waiting in the transmit queue in the master role, or the number of unread received words in the slave role. The value saturates at 7.
- R5: Status bit 3 is 1 while the shifter is idle and 0 while a word is in progress.
- R6: If a word completes while the receive queue holds 8 words, the word is dropped and status bit 4 sets. Bit 4 stays set until a status write with bit 4 at 1.
- R7: Status bit 5 is receive-empty, bit 6 is transmit-full and bit 7 is receive-full. A data write to a full transmit queue is dropped. Status writes with bit 4 at 0 change nothing.
- R8: Control bits 6:4 select the interrupt source. The level sources are 111 (transmit full), 011 (receive full), 010 (receive holds 6 or more) and 001 (receive not empty). irq follows the selected condition with one cycle of latency.
- R9: The edge sources give a one-cycle irq pulse. 110 fires when a word leaves the transmit queue and leaves it empty. 101 fires when a word finishes with the transmit queue empty. 100 fires when a word leaves a full transmit queue. 000 fires when a read takes the last received word.
- R10: With control bit 1 set and idle_in high, the serial engine is frozen: sck_out, ss_n_out and sdo hold, and no new word starts. Data resumes intact once idle_in falls.
- R11: In the slave role, sck_in, ss_n_in and sdi each pass through two flip-flops before edge detection. On the falling edge of ss_n_in the slave loads the next transmit word, or zeros if the queue is empty. It captures sdi on each rising edge and shifts sdo on each falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| idle_in | input | 1 | System idle indication |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on the data address) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| port_owned | output | 1 | Serial pins are driven by the port |
| sck_out | output | 1 | Serial clock in master role |
| ss_n_out | output | 1 | Active-low select in master role |
| sdo | output | 1 | Serial data out |
| sck_in | input | 1 | Serial clock in slave role |
| ss_n_in | input | 1 | Active-low select in slave role |
| sdi | input | 1 | Serial data in |

## Verification
A wrong queue count shows up in status bits 2:0 or 7:5 at the next register read. It also shows up as a missing or extra irq cycle one clock after the event. A corrupted shift register, or an off-by-one bit counter, appears within one word time (about 16*HALF_DIV clocks) as a wrong byte on sdo or in the receive queue, or as a clock edge outside the select window. A lost overflow flag or a wrongly stored dropped word is seen when the receive queue is drained in order after the overflow.

// File: rtl/spibuf_pkg.sv
// Shared types for the buffered SPI port: interrupt source encodings,
// register addresses and status bit positions.
package spibuf_pkg;

    typedef enum logic [2:0] {
        IS_RX_DRAINED = 3'b000,
        IS_RX_ANY     = 3'b001,
        IS_RX_3Q      = 3'b010,
        IS_RX_FULL    = 3'b011,
        IS_TX_SLOT    = 3'b100,
        IS_TX_DONE    = 3'b101,
        IS_TX_DRAINED = 3'b110,
        IS_TX_FULL    = 3'b111
    } isel_e;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;

    localparam int SB_SREMPTY = 3;
    localparam int SB_OVF     = 4;
    localparam int SB_RXEMPTY = 5;
    localparam int SB_TXFULL  = 6;
    localparam int SB_RXFULL  = 7;

endpackage

// File: rtl/spibuf_fifo.sv
// Synchronous queue with occupancy count.
// Assumes DEPTH >= 2. A push to a full queue and a pop from an empty queue
// are ignored. flush empties the queue on the next edge.
module spibuf_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  wdata,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] count,
    output logic          empty,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp];

    // Storage write; contents need no reset because count guards reads.
    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    p_count_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    p_full_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        full && push && !pop && !flush |=> full);

endmodule

// File: rtl/spibuf_shift.sv
// Serial engine, clock mode 0 only.
// In the master role it divides clk by 2*HALF_DIV and drives select low for
// each word. In the slave role the external clock, select and data each pass
// through two flip-flops, and a third stage detects edges.
// Assumes that in the master role sdi is synchronous to clk.
// run=0 resets the engine; hold=1 freezes it.
module spibuf_shift #(
    parameter int W        = 8,
    parameter int HALF_DIV = 4,
    localparam int BW      = $clog2(W + 1),
    localparam int DW      = $clog2(HALF_DIV + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         hold,
    input  logic         master,
    input  logic         tx_valid,
    input  logic [W-1:0] tx_data,
    output logic         tx_pop,
    output logic         word_done,
    output logic [W-1:0] rx_word,
    output logic         busy,
    input  logic         sck_in,
    input  logic         ss_n_in,
    input  logic         sdi,
    output logic         sck_out,
    output logic         ss_n_out,
    output logic         sdo
);
    logic [W-1:0]  tx_sh, rx_sh;
    logic [BW-1:0] bitcnt;
    logic [DW-1:0] div;
    logic          sck_r, ss_r;
    logic [2:0]    sck_sy, ss_sy;
    logic [1:0]    sdi_sy;
    logic          s_rise, s_fall, s_sel;

    assign s_rise    = sck_sy[1] && !sck_sy[2];
    assign s_fall    = !sck_sy[1] && sck_sy[2];
    assign s_sel     = !ss_sy[1];
    assign tx_pop    = run && !hold && !busy && tx_valid && (master || s_sel);
    assign rx_word   = rx_sh;
    assign sck_out   = master && sck_r;
    assign ss_n_out  = master ? ss_r : 1'b1;
    assign sdo       = busy && tx_sh[W-1];

    // Two-stage synchronisers plus an edge-detect stage for the slave pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy <= '0;
            ss_sy  <= '1;
            sdi_sy <= '0;
        end else begin
            sck_sy <= {sck_sy[1:0], sck_in};
            ss_sy  <= {ss_sy[1:0], ss_n_in};
            sdi_sy <= {sdi_sy[0], sdi};
        end
    end

    // Word sequencing for both roles.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            busy      <= 1'b0;
            sck_r     <= 1'b0;
            ss_r      <= 1'b1;
            div       <= '0;
            bitcnt    <= '0;
            tx_sh     <= '0;
            rx_sh     <= '0;
            word_done <= 1'b0;
        end else begin
            word_done <= 1'b0;
            if (!hold) begin
                if (master) begin
                    if (!busy) begin
                        if (tx_valid) begin
                            busy   <= 1'b1;
                            ss_r   <= 1'b0;
                            tx_sh  <= tx_data;
                            bitcnt <= '0;
                            div    <= '0;
                        end
                    end else if (div == DW'(HALF_DIV - 1)) begin
                        div <= '0;
                        if (!sck_r) begin
                            sck_r  <= 1'b1;
                            rx_sh  <= {rx_sh[W-2:0], sdi};
                            bitcnt <= bitcnt + 1'b1;
                        end else begin
                            sck_r <= 1'b0;
                            if (bitcnt == BW'(W)) begin
                                busy      <= 1'b0;
                                ss_r      <= 1'b1;
                                word_done <= 1'b1;
                            end else begin
                                tx_sh <= {tx_sh[W-2:0], 1'b0};
                            end
                        end
                    end else begin
                        div <= div + 1'b1;
                    end
                end else begin
                    sck_r <= 1'b0;
                    ss_r  <= 1'b1;
                    if (!s_sel) begin
                        busy   <= 1'b0;
                        bitcnt <= '0;
                    end else if (!busy) begin
                        busy   <= 1'b1;
                        tx_sh  <= tx_valid ? tx_data : '0;
                        bitcnt <= '0;
                    end else if (s_rise) begin
                        rx_sh <= {rx_sh[W-2:0], sdi_sy[1]};
                        if (bitcnt == BW'(W - 1)) begin
                            busy      <= 1'b0;
                            bitcnt    <= '0;
                            word_done <= 1'b1;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end else if (s_fall && bitcnt != '0) begin
                        tx_sh <= {tx_sh[W-2:0], 1'b0};
                    end
                end
            end
        end
    end

    p_sck_in_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
        master && ss_n_out |-> !sck_out);

    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(run) && $past(hold) && run && hold
        |-> $stable(sck_out) && $stable(ss_n_out) && $stable(sdo));

endmodule

// File: rtl/spibuf_irq.sv
// Interrupt source selection. Level sources follow their condition and edge
// sources pulse for one cycle on their event. The output is registered, so it
// shows one cycle after the condition or event.
module spibuf_irq
    import spibuf_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  en,
    input  isel_e sel,
    input  logic  tx_full,
    input  logic  tx_empty,
    input  logic  tx_one,
    input  logic  tx_pop,
    input  logic  word_done,
    input  logic  rx_empty,
    input  logic  rx_one,
    input  logic  rx_3q,
    input  logic  rx_full,
    input  logic  rx_pop,
    output logic  irq
);
    logic cond;
    logic is_edge;

    assign is_edge = (sel == IS_RX_DRAINED) || (sel == IS_TX_SLOT) ||
                     (sel == IS_TX_DONE)    || (sel == IS_TX_DRAINED);

    // Pick the selected condition or event.
    always_comb begin
        unique case (sel)
            IS_RX_DRAINED: cond = rx_pop && rx_one;
            IS_RX_ANY:     cond = !rx_empty;
            IS_RX_3Q:      cond = rx_3q;
            IS_RX_FULL:    cond = rx_full;
            IS_TX_SLOT:    cond = tx_pop && tx_full;
            IS_TX_DONE:    cond = word_done && tx_empty;
            IS_TX_DRAINED: cond = tx_pop && tx_one;
            IS_TX_FULL:    cond = tx_full;
            default:       cond = 1'b0;
        endcase
    end

    // Register the request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= en && cond;
    end

    p_edge_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_edge && irq |=> (!irq || !$stable(sel)));

endmodule

// File: rtl/spibuf_ctrl.sv
// Buffered SPI port top level: register port, control and status, transmit and
// receive queues, the serial engine and the interrupt selector.
// Assumes W >= 8 so that every control and status field fits the data bus.
module spibuf_ctrl
    import spibuf_pkg::*;
#(
    parameter int W        = 8,
    parameter int DEPTH    = 8,
    parameter int HALF_DIV = 4,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int THREEQ  = (3 * DEPTH + 3) / 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         idle_in,
    input  logic [1:0]   reg_addr,
    input  logic         reg_wr,
    input  logic         reg_rd,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    output logic         irq,
    output logic         port_owned,
    output logic         sck_out,
    output logic         ss_n_out,
    output logic         sdo,
    input  logic         sck_in,
    input  logic         ss_n_in,
    input  logic         sdi
);
    logic          en_q, stop_q, mst_q, ovf_q;
    isel_e         sel_q;
    logic          hold, tx_push, rx_pop_req, ovf_clr;
    logic [W-1:0]  tx_head, rx_head, rx_word;
    logic [CW-1:0] tx_cnt, rx_cnt, cnt_src;
    logic          tx_empty, tx_full, rx_empty, rx_full;
    logic          tx_pop, word_done, busy, rx_push;
    logic [2:0]    cnt_field;
    logic          unused_bits;

    assign hold       = stop_q && idle_in;
    assign tx_push    = reg_wr && reg_addr == A_DATA && en_q;
    assign rx_pop_req = reg_rd && reg_addr == A_DATA && en_q;
    assign ovf_clr    = reg_wr && reg_addr == A_STAT && reg_wdata[SB_OVF];
    assign rx_push    = word_done && !rx_full;
    assign port_owned = en_q;
    assign cnt_src    = mst_q ? tx_cnt : rx_cnt;
    assign cnt_field  = (int'(cnt_src) > 7) ? 3'd7 : 3'(cnt_src);
    assign unused_bits = &{1'b0, reg_wdata[W-1:7], reg_wdata[3]};

    // Control register write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            stop_q <= 1'b0;
            mst_q  <= 1'b0;
            sel_q  <= IS_RX_DRAINED;
        end else if (reg_wr && reg_addr == A_CTRL) begin
            en_q   <= reg_wdata[0];
            stop_q <= reg_wdata[1];
            mst_q  <= reg_wdata[2];
            sel_q  <= isel_e'(reg_wdata[6:4]);
        end
    end

    // Sticky overflow flag; a new overflow wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      ovf_q <= 1'b0;
        else if (word_done && rx_full)   ovf_q <= 1'b1;
        else if (ovf_clr)                ovf_q <= 1'b0;
    end

    // Register read mux.
    always_comb begin
        reg_rdata = '0;
        unique case (reg_addr)
            A_CTRL: begin
                reg_rdata[0]   = en_q;
                reg_rdata[1]   = stop_q;
                reg_rdata[2]   = mst_q;
                reg_rdata[6:4] = sel_q;
            end
            A_STAT: begin
                reg_rdata[2:0]        = cnt_field;
                reg_rdata[SB_SREMPTY] = !busy;
                reg_rdata[SB_OVF]     = ovf_q;
                reg_rdata[SB_RXEMPTY] = rx_empty;
                reg_rdata[SB_TXFULL]  = tx_full;
                reg_rdata[SB_RXFULL]  = rx_full;
            end
            A_DATA:  reg_rdata = rx_empty ? '0 : rx_head;
            default: reg_rdata = '0;
        endcase
    end

    spibuf_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(!en_q),
        .push(tx_push), .wdata(reg_wdata), .pop(tx_pop),
        .head(tx_head), .count(tx_cnt), .empty(tx_empty), .full(tx_full)
    );

    spibuf_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(!en_q),
        .push(rx_push), .wdata(rx_word), .pop(rx_pop_req),
        .head(rx_head), .count(rx_cnt), .empty(rx_empty), .full(rx_full)
    );

    spibuf_shift #(.W(W), .HALF_DIV(HALF_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .run(en_q), .hold(hold), .master(mst_q),
        .tx_valid(!tx_empty), .tx_data(tx_head), .tx_pop(tx_pop),
        .word_done(word_done), .rx_word(rx_word), .busy(busy),
        .sck_in(sck_in), .ss_n_in(ss_n_in), .sdi(sdi),
        .sck_out(sck_out), .ss_n_out(ss_n_out), .sdo(sdo)
    );

    spibuf_irq u_irq (
        .clk(clk), .rst_n(rst_n), .en(en_q), .sel(sel_q),
        .tx_full(tx_full), .tx_empty(tx_empty), .tx_one(tx_cnt == CW'(1)),
        .tx_pop(tx_pop), .word_done(word_done),
        .rx_empty(rx_empty), .rx_one(rx_cnt == CW'(1)),
        .rx_3q(rx_cnt >= CW'(THREEQ)), .rx_full(rx_full),
        .rx_pop(rx_pop_req && !rx_empty), .irq(irq)
    );

    p_ovf_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_q && !ovf_clr |=> ovf_q);

    p_idle_pins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |=> ss_n_out && !sck_out && !sdo);

    p_busy_select_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mst_q && !ss_n_out |-> busy);

endmodule

// File: tb/tb_spibuf_ctrl.sv
`timescale 1ns/100ps
module tb_spibuf_ctrl;
    localparam int HALF = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       idle_in = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq, port_owned, sck_out, ss_n_out, sdo;
    logic       sck_in = 1'b0, ss_n_in = 1'b1, sdi_drv = 1'b0, loop_en = 1'b1;
    logic       sdi;

    int checks = 0, fails = 0;
    int irq_hi = 0;
    int cyc = 0;
    int rises = 0, rise_t1 = 0, rise_t2 = 0, rise_open = 0;
    int mon_bits = 0, mon_n = 0;
    logic [7:0] mon_sh = 8'h00;
    logic [7:0] mon_q [16];
    logic prev_sck = 1'b0;

    assign sdi = loop_en ? sdo : sdi_drv;

    always #2.5 clk = ~clk;

    spibuf_ctrl #(.W(8), .DEPTH(8), .HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .idle_in(idle_in), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq), .port_owned(port_owned),
        .sck_out(sck_out), .ss_n_out(ss_n_out), .sdo(sdo),
        .sck_in(sck_in), .ss_n_in(ss_n_in), .sdi(sdi)
    );

    // Serial monitor in the master role, plus an irq cycle counter.
    always @(negedge clk) begin
        cyc = cyc + 1;
        if (irq) irq_hi = irq_hi + 1;
        if (sck_out && !prev_sck) begin
            rises = rises + 1;
            if (rises == 1) rise_t1 = cyc;
            if (rises == 2) rise_t2 = cyc;
            if (ss_n_out) rise_open = rise_open + 1;
            mon_sh = {mon_sh[6:0], sdo};
            mon_bits = mon_bits + 1;
            if (mon_bits == 8) begin
                mon_q[mon_n % 16] = mon_sh;
                mon_n = mon_n + 1;
                mon_bits = 0;
            end
        end
        prev_sck = sck_out;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); chk("R1 ctrl", d, 8'h00);
        rd(2'd1, d); chk("R1 status", d, 8'h28);
        chk("R1 pins", {irq, port_owned, ss_n_out, sck_out}, 4'b0010);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        int low = 0;
        wr(2'd0, 8'h04);
        wr(2'd2, 8'h55);
        rd(2'd1, d); chk("R2 write dropped", d, 8'h28);
        chk("R2 port_owned off", port_owned, 1'b0);
        wr(2'd0, 8'h05);
        chk("R2 port_owned on", port_owned, 1'b1);
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!ss_n_out) low++;
        end
        chk("R2 no transfer after enable", low, 0);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_master();
        logic [7:0] d;
        int moved = 0;
        logic s0, s1;
        idle_in = 1'b1;
        wr(2'd0, 8'h07);
        wr(2'd2, 8'hA5); wr(2'd2, 8'h3C); wr(2'd2, 8'h81);
        rd(2'd1, d); chk("R4 master pending count", d, 8'h2B);
        @(negedge clk); idle_in = 1'b0;
        wait_cyc(5);
        rd(2'd1, d); chk("R5 shifter busy", d, 8'h22);
        wait_cyc(25);
        idle_in = 1'b1;
        wait_cyc(2);
        s0 = sck_out; s1 = ss_n_out;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sck_out !== s0 || ss_n_out !== s1) moved++;
        end
        chk("R10 frozen pins", moved, 0);
        chk("R10 select held low", s1, 1'b0);
        idle_in = 1'b0;
        wait_cyc(260);
        chk("R3 words seen", mon_n, 3);
        chk("R3 word0", mon_q[0], 8'hA5);
        chk("R3 word1", mon_q[1], 8'h3C);
        chk("R3 word2", mon_q[2], 8'h81);
        chk("R3 sck period", rise_t2 - rise_t1, 2 * HALF);
        chk("R3 edges inside select", rise_open, 0);
        rd(2'd1, d); chk("R5 idle after words", d, 8'h08);
        rd(2'd2, d); chk("R3 rx0", d, 8'hA5);
        rd(2'd2, d); chk("R3 rx1", d, 8'h3C);
        rd(2'd2, d); chk("R3 rx2", d, 8'h81);
        rd(2'd1, d); chk("R7 rx empty", d, 8'h28);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_buffers();
        logic [7:0] d;
        idle_in = 1'b1;
        wr(2'd0, 8'h77);
        for (int i = 0; i < 8; i++) wr(2'd2, 8'(i * 8'h11 + 1));
        wait_cyc(2);
        chk("R8 tx full level", irq, 1'b1);
        rd(2'd1, d); chk("R4 saturated count and R7 tx full", d, 8'h6F);
        wr(2'd2, 8'hFF);
        wr(2'd0, 8'h47);
        wait_cyc(2);
        chk("R8 level drops on reselect", irq, 1'b0);
        irq_hi = 0;
        idle_in = 1'b0;
        wait_cyc(8 * 80 + 40);
        chk("R9 one slot pulse", irq_hi, 1);
        rd(2'd1, d); chk("R7 rx full", d, 8'h88);
        wr(2'd0, 8'h37); wait_cyc(2); chk("R8 rx full level", irq, 1'b1);
        wr(2'd0, 8'h27); wait_cyc(2); chk("R8 rx 3q level", irq, 1'b1);
        wr(2'd0, 8'h17); wait_cyc(2); chk("R8 rx any level", irq, 1'b1);
        wr(2'd2, 8'hEE);
        wait_cyc(100);
        rd(2'd1, d); chk("R6 overflow set", d, 8'h98);
        wr(2'd1, 8'hEF);
        rd(2'd1, d); chk("R7 status write without clear", d, 8'h98);
        rd(2'd2, d); chk("R6 oldest kept 0", d, 8'h01);
        rd(2'd2, d); chk("R6 oldest kept 1", d, 8'h12);
        wr(2'd0, 8'h27); wait_cyc(2); chk("R8 six held", irq, 1'b1);
        rd(2'd2, d); chk("R6 word 2", d, 8'h23);
        wait_cyc(2); chk("R8 five held", irq, 1'b0);
        wr(2'd0, 8'h07); wait_cyc(2);
        irq_hi = 0;
        for (int i = 3; i < 8; i++) begin
            rd(2'd2, d); chk("R7 drain order", d, 8'(i * 8'h11 + 1));
        end
        wait_cyc(2);
        chk("R9 last read pulse", irq_hi, 1);
        rd(2'd1, d); chk("R6 flag still set", d, 8'h38);
        wr(2'd1, 8'h10);
        rd(2'd1, d); chk("R6 flag cleared", d, 8'h28);
        wr(2'd0, 8'h00);
    endtask

    task automatic t_tx_events(input logic [7:0] ctrl, input string tag);
        logic [7:0] d;
        idle_in = 1'b1;
        wr(2'd0, ctrl);
        wr(2'd2, 8'h11); wr(2'd2, 8'h22); wr(2'd2, 8'h33);
        wait_cyc(3);
        irq_hi = 0;
        idle_in = 1'b0;
        wait_cyc(300);
        chk(tag, irq_hi, 1);
        for (int i = 0; i < 3; i++) rd(2'd2, d);
        wr(2'd0, 8'h00);
    endtask

    task automatic slave_word(input logic [7:0] mosi, output logic [7:0] miso);
        for (int i = 7; i >= 0; i--) begin
            sdi_drv = mosi[i];
            wait_cyc(2 * HALF);
            miso[i] = sdo;
            sck_in = 1'b1;
            wait_cyc(2 * HALF);
            sck_in = 1'b0;
        end
        wait_cyc(8);
    endtask

    task automatic t_slave();
        logic [7:0] d, m;
        loop_en = 1'b0;
        wr(2'd0, 8'h01);
        wr(2'd2, 8'hC3);
        rd(2'd1, d); chk("R4 slave count empty", d, 8'h28);
        @(negedge clk); ss_n_in = 1'b0;
        wait_cyc(8);
        rd(2'd1, d); chk("R5 slave busy", d, 8'h20);
        slave_word(8'h5A, m);
        chk("R11 slave sends queued word", m, 8'hC3);
        ss_n_in = 1'b1; wait_cyc(8);
        rd(2'd1, d); chk("R4 slave unread one", d, 8'h09);
        ss_n_in = 1'b0; wait_cyc(8);
        slave_word(8'h96, m);
        chk("R11 slave sends zeros when empty", m, 8'h00);
        ss_n_in = 1'b1; wait_cyc(8);
        rd(2'd1, d); chk("R4 slave unread two", d, 8'h0A);
        rd(2'd2, d); chk("R11 slave rx0", d, 8'h5A);
        rd(2'd2, d); chk("R11 slave rx1", d, 8'h96);
        chk("R11 master pins idle", {sck_out, ss_n_out}, 2'b01);
        wr(2'd0, 8'h00);
        loop_en = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        wait_cyc(5);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset();
        t_disabled();
        t_master();
        t_buffers();
        t_tx_events(8'h67, "R9 drained pulse");
        t_tx_events(8'h57, "R9 done pulse");
        t_slave();
        finish_run();
    end

endmodule